// File: doc/BRIEF.md
# Page-Granular Block Presence Tracker

This block sits in front of a large DRAM cache and tells, for every request, whether the addressed 64-byte block is held in that cache, without any DRAM access. It keeps a set-associative table of page entries. Each entry has a page tag and a presence vector with one bit per block of a 4 KB page. A "not present" answer lets the request bypass the DRAM cache and go straight to off-chip memory. A "present" answer carries no way information. The DRAM cache's own tags locate the block.

The table covers more pages than the DRAM cache can hold at once, so page entries are rarely displaced. A fill port sets a presence bit and allocates an entry for an untracked page. An evict port clears a bit, and it frees the entry once its vector is empty. When an allocation has to push out a live entry, the tracker presents that page and its vector on a victim port with a valid/ready handshake. The cache must then drop those blocks, so that presence is never reported lower than the truth.

Inputs are block addresses, that is byte addresses shifted right by six. With the default parameters the block index is bits [5:0], the set index is bits [13:6] and the page tag is bits [33:14]. The table has 256 sets of 4 ways. Replacement is true LRU, ordered by fill activity.

Top module: `ppt_presence_tracker`

## Requirements
- R1: After a synchronous active-low reset, no page is tracked. Every lookup reports absent, `vic_valid` and `rsp_valid` are low, and `upd_ready` is high.
- R2: A fill (`upd_op`=0) of block address A makes later lookups of A report present. Other blocks of the same page, and the same block index in other pages, stay absent.
- R3: Each lookup gives exactly one response, with `rsp_valid` high in the cycle after `lkp_valid`. Lookups may be issued back to back, and `rsp_valid` never rises without a lookup in the previous cycle.
- R4: A lookup issued in the same cycle as an accepted fill of the same block address reports present.
- R5: A lookup issued in the same cycle as an accepted evict (`upd_op`=1) of the same block address reports absent.
- R6: An evict of a block clears only that block's bit. The other present blocks of the page stay present.
- R7: When an evict clears the last set bit of a page, that page's entry is freed. The next allocation in the set reuses it without raising `vic_valid`.
- R8: An evict that targets an untracked page, or a clear bit of a tracked page, changes no lookup result. It raises no victim and does not change the replacement order.
- R9: A fill to an untracked page uses a free way of its set if there is one. Otherwise it displaces the least recently filled page and presents that page number (block address bits [33:6]) and its full presence vector on `vic_page`/`vic_vec`. Lookups of the displaced page then report absent.
- R10: Recency is set by fills only. A fill of an already tracked page, even one whose bit is already set, makes that page most recent. Lookups leave the order unchanged.
- R11: While `vic_valid` is high and `vic_ready` is low, the victim page and vector are held stable and `upd_ready` is low. The victim is retired in a cycle where `vic_valid` and `vic_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_valid | input | 1 | Lookup request |
| lkp_blk_addr | input | 34 | Block address to look up |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_present | output | 1 | 1 = block present in the DRAM cache |
| upd_valid | input | 1 | Update request |
| upd_op | input | 1 | 0 = fill (set bit), 1 = evict (clear bit) |
| upd_blk_addr | input | 34 | Block address of the update |
| upd_ready | output | 1 | Update accepted when high together with upd_valid |
| vic_valid | output | 1 | Displaced page waiting to be evicted from the cache |
| vic_ready | input | 1 | Consumer accepts the displaced page |
| vic_page | output | 28 | Page number of the displaced entry |
| vic_vec | output | 64 | Presence vector of the displaced entry |

## Verification
A corrupted presence vector or tag shows up on the next lookup of the affected block, one cycle after the request. A corrupted replacement order stays hidden until a set fills up. It then surfaces as the wrong page on `vic_page` in the cycle after the fill that displaces it. The bench therefore fills one set past its capacity in several orders, with refreshes, lookups, frees and harmless evicts mixed in. It checks each victim's identity and vector, and probes lookups on both sides of each update, including the same cycle.

// File: rtl/ppt_pkg.sv
// Shared types for the page presence tracker.
package ppt_pkg;

    // Update operation; encoding is visible on the upd_op port.
    typedef enum logic {
        OP_FILL  = 1'b0,
        OP_EVICT = 1'b1
    } upd_op_e;

endpackage

// File: rtl/ppt_entry_array.sv
// Storage of page entries: per set and way a valid flag, a page tag and a
// presence vector. Two combinational read ports (lookup, update) and one
// write port. Assumes at most one write per cycle; only valid flags reset.
module ppt_entry_array #(
    parameter int SETS  = 256,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int BLKS  = 64,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SET_W-1:0]                 rda_set,
    output logic [WAYS-1:0]                  rda_valid,
    output logic [WAYS-1:0][TAG_W-1:0]       rda_tag,
    output logic [WAYS-1:0][BLKS-1:0]        rda_vec,
    input  logic [SET_W-1:0]                 rdb_set,
    output logic [WAYS-1:0]                  rdb_valid,
    output logic [WAYS-1:0][TAG_W-1:0]       rdb_tag,
    output logic [WAYS-1:0][BLKS-1:0]        rdb_vec,
    input  logic                             wr_en,
    input  logic [SET_W-1:0]                 wr_set,
    input  logic [WAY_W-1:0]                 wr_way,
    input  logic                             wr_valid,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic [BLKS-1:0]                  wr_vec
);

    logic [WAYS-1:0]  val_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [BLKS-1:0]  vec_q [SETS][WAYS];

    // Valid flags: cleared by reset, written by the update path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
            end
        end else if (wr_en) begin
            val_q[wr_set][wr_way] <= wr_valid;
        end
    end

    // Tag and vector payload: no reset, only read when the valid flag is set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            vec_q[wr_set][wr_way] <= wr_vec;
        end
    end

    assign rda_valid = val_q[rda_set];
    assign rdb_valid = val_q[rdb_set];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_read
        assign rda_tag[gw] = tag_q[rda_set][gw];
        assign rda_vec[gw] = vec_q[rda_set][gw];
        assign rdb_tag[gw] = tag_q[rdb_set][gw];
        assign rdb_vec[gw] = vec_q[rdb_set][gw];
    end

endmodule

// File: rtl/ppt_lru_ages.sv
// True-LRU state per set as a permutation of ages (0 = newest). Queries and
// touches address the same set in a cycle; the query sees the pre-touch state.
// Assumes WAYS is a power of two and at least 2.
module ppt_lru_ages #(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] oldest_way
);

    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] cur_age;
    logic [WAYS-1:0][WAY_W-1:0] nxt_age;

    assign cur_age = age_q[set_idx];

    // Pick the way holding the maximum age.
    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cur_age[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
        end
    end

    // Age every way younger than the touched one, then make it newest.
    always_comb begin
        nxt_age = cur_age;
        for (int w = 0; w < WAYS; w++) begin
            if (cur_age[w] < cur_age[touch_way]) nxt_age[w] = cur_age[w] + WAY_W'(1);
        end
        nxt_age[touch_way] = '0;
    end

    // Reset loads the identity permutation; touches rewrite one set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            age_q[set_idx] <= nxt_age;
        end
    end

endmodule

// File: rtl/ppt_update_ctrl.sv
// Combinational decision for one accepted fill or evict against the ways of
// one set: hit detection, free-way/LRU allocation, new vector, displacement.
// Assumes a valid entry never holds an all-zero vector.
module ppt_update_ctrl
    import ppt_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int BLKS  = 64,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int BIDX_W = $clog2(BLKS)
) (
    input  logic                       fire,
    input  upd_op_e                    op,
    input  logic [TAG_W-1:0]           tag,
    input  logic [BIDX_W-1:0]          bidx,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][BLKS-1:0]  way_vec,
    input  logic [WAY_W-1:0]           lru_way,
    output logic                       wr_en,
    output logic [WAY_W-1:0]           wr_way,
    output logic                       wr_valid,
    output logic [BLKS-1:0]            wr_vec,
    output logic                       touch_en,
    output logic                       displace,
    output logic [TAG_W-1:0]           dsp_tag,
    output logic [BLKS-1:0]            dsp_vec
);

    logic [WAYS-1:0]  way_hit;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             has_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] alloc_way;
    logic [BLKS-1:0]  blk_mask;
    logic [BLKS-1:0]  hit_vec;

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
        assign way_hit[gw] = way_valid[gw] && (way_tag[gw] == tag);
    end

    // Encode the matching way and the lowest-numbered free way.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        has_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
            if (!way_valid[w]) begin
                free_way = WAY_W'(w);
                has_free = 1'b1;
            end
        end
    end

    assign hit       = |way_hit;
    assign alloc_way = has_free ? free_way : lru_way;
    assign blk_mask  = BLKS'(1) << bidx;
    assign hit_vec   = way_vec[hit_way];

    // Build the single write and the recency touch for this update.
    always_comb begin
        wr_en    = 1'b0;
        wr_way   = hit ? hit_way : alloc_way;
        wr_valid = 1'b1;
        wr_vec   = blk_mask;
        touch_en = 1'b0;
        if (fire && op == OP_FILL) begin
            wr_en    = 1'b1;
            touch_en = 1'b1;
            wr_vec   = hit ? (hit_vec | blk_mask) : blk_mask;
        end else if (fire && op == OP_EVICT && hit) begin
            wr_en    = 1'b1;
            wr_vec   = hit_vec & ~blk_mask;
            wr_valid = |(hit_vec & ~blk_mask);
        end
    end

    assign displace = fire && (op == OP_FILL) && !hit && !has_free;
    assign dsp_tag  = way_tag[lru_way];
    assign dsp_vec  = way_vec[lru_way];

endmodule

// File: rtl/ppt_presence_tracker.sv
// Page-granular block presence tracker. Answers block presence one cycle
// after a lookup, forwarding a same-cycle update of the same block. Updates
// are stalled while a displaced page waits on the victim port.
module ppt_presence_tracker
    import ppt_pkg::*;
#(
    parameter int BLK_ADDR_W = 34,
    parameter int PAGE_BLKS  = 64,
    parameter int SETS       = 256,
    parameter int WAYS       = 4,
    localparam int BIDX_W = $clog2(PAGE_BLKS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int PAGE_W = BLK_ADDR_W - BIDX_W,
    localparam int TAG_W  = PAGE_W - SET_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lkp_valid,
    input  logic [BLK_ADDR_W-1:0] lkp_blk_addr,
    output logic                  rsp_valid,
    output logic                  rsp_present,
    input  logic                  upd_valid,
    input  logic                  upd_op,
    input  logic [BLK_ADDR_W-1:0] upd_blk_addr,
    output logic                  upd_ready,
    output logic                  vic_valid,
    input  logic                  vic_ready,
    output logic [PAGE_W-1:0]     vic_page,
    output logic [PAGE_BLKS-1:0]  vic_vec
);

    // Address fields of both ports.
    logic [BIDX_W-1:0] lk_bidx, up_bidx;
    logic [SET_W-1:0]  lk_set, up_set;
    logic [TAG_W-1:0]  lk_tag, up_tag;

    assign lk_bidx = lkp_blk_addr[BIDX_W-1:0];
    assign lk_set  = lkp_blk_addr[BIDX_W +: SET_W];
    assign lk_tag  = lkp_blk_addr[BLK_ADDR_W-1 -: TAG_W];
    assign up_bidx = upd_blk_addr[BIDX_W-1:0];
    assign up_set  = upd_blk_addr[BIDX_W +: SET_W];
    assign up_tag  = upd_blk_addr[BLK_ADDR_W-1 -: TAG_W];

    logic    upd_fire;
    upd_op_e op;
    assign op       = upd_op_e'(upd_op);
    assign upd_fire = upd_valid && upd_ready;

    // Read data from the entry array.
    logic [WAYS-1:0]                 lk_valid, up_valid;
    logic [WAYS-1:0][TAG_W-1:0]      lk_tagv, up_tagv;
    logic [WAYS-1:0][PAGE_BLKS-1:0]  lk_vec, up_vec;

    // Update decision.
    logic                 wr_en, wr_valid, touch_en, displace;
    logic [WAY_W-1:0]     wr_way, lru_way;
    logic [PAGE_BLKS-1:0] wr_vec, dsp_vec;
    logic [TAG_W-1:0]     dsp_tag;

    ppt_entry_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .BLKS(PAGE_BLKS)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .rda_set(lk_set), .rda_valid(lk_valid), .rda_tag(lk_tagv), .rda_vec(lk_vec),
        .rdb_set(up_set), .rdb_valid(up_valid), .rdb_tag(up_tagv), .rdb_vec(up_vec),
        .wr_en(wr_en), .wr_set(up_set), .wr_way(wr_way), .wr_valid(wr_valid),
        .wr_tag(up_tag), .wr_vec(wr_vec)
    );

    ppt_lru_ages #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_lru (
        .clk(clk), .rst_n(rst_n), .set_idx(up_set),
        .touch_en(touch_en), .touch_way(wr_way), .oldest_way(lru_way)
    );

    ppt_update_ctrl #(
        .WAYS(WAYS), .TAG_W(TAG_W), .BLKS(PAGE_BLKS)
    ) u_upd (
        .fire(upd_fire), .op(op), .tag(up_tag), .bidx(up_bidx),
        .way_valid(up_valid), .way_tag(up_tagv), .way_vec(up_vec), .lru_way(lru_way),
        .wr_en(wr_en), .wr_way(wr_way), .wr_valid(wr_valid), .wr_vec(wr_vec),
        .touch_en(touch_en), .displace(displace), .dsp_tag(dsp_tag), .dsp_vec(dsp_vec)
    );

    // Lookup: per-way tag and bit match.
    logic [WAYS-1:0] lk_way_match;
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_lkp
        assign lk_way_match[gw] = lk_valid[gw] && (lk_tagv[gw] == lk_tag) && lk_vec[gw][lk_bidx];
    end

    logic fwd_hit;
    logic present_d;
    assign fwd_hit   = upd_fire && (upd_blk_addr == lkp_blk_addr);
    assign present_d = fwd_hit ? (op == OP_FILL) : (|lk_way_match);

    // Register the lookup response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_present <= 1'b0;
        end else begin
            rsp_valid   <= lkp_valid;
            rsp_present <= lkp_valid && present_d;
        end
    end

    // Victim holding register with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid <= 1'b0;
            vic_page  <= '0;
            vic_vec   <= '0;
        end else if (displace) begin
            vic_valid <= 1'b1;
            vic_page  <= {dsp_tag, up_set};
            vic_vec   <= dsp_vec;
        end else if (vic_valid && vic_ready) begin
            vic_valid <= 1'b0;
        end
    end

    assign upd_ready = !vic_valid;

endmodule

// File: rtl/ppt_presence_checker.sv
// Port-level properties of the presence tracker, bound to the top module.
module ppt_presence_checker #(
    parameter int BLK_ADDR_W = 34,
    parameter int PAGE_BLKS  = 64,
    localparam int PAGE_W = BLK_ADDR_W - $clog2(PAGE_BLKS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lkp_valid,
    input logic [BLK_ADDR_W-1:0] lkp_blk_addr,
    input logic                  rsp_valid,
    input logic                  rsp_present,
    input logic                  upd_valid,
    input logic                  upd_op,
    input logic [BLK_ADDR_W-1:0] upd_blk_addr,
    input logic                  upd_ready,
    input logic                  vic_valid,
    input logic                  vic_ready,
    input logic [PAGE_W-1:0]     vic_page,
    input logic [PAGE_BLKS-1:0]  vic_vec
);

    logic same_blk;
    assign same_blk = lkp_valid && upd_valid && upd_ready && (lkp_blk_addr == upd_blk_addr);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid); // R3
    AST_RSP_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid); // R3
    AST_FWD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (same_blk && !upd_op) |=> rsp_present); // R4
    AST_FWD_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (same_blk && upd_op) |=> !rsp_present); // R5
    AST_VIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_page) && $stable(vic_vec))); // R11
    AST_VIC_STALLS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> !upd_ready); // R11
    AST_VIC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> (vic_vec != '0)); // R9
    AST_VIC_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vic_valid) |-> $past(upd_valid && upd_ready && !upd_op)); // R9

endmodule

bind ppt_presence_tracker ppt_presence_checker #(
    .BLK_ADDR_W(BLK_ADDR_W), .PAGE_BLKS(PAGE_BLKS)
) u_checker (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_blk_addr(lkp_blk_addr),
    .rsp_valid(rsp_valid), .rsp_present(rsp_present), .upd_valid(upd_valid),
    .upd_op(upd_op), .upd_blk_addr(upd_blk_addr), .upd_ready(upd_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_page(vic_page), .vic_vec(vic_vec)
);

// File: tb/test_ppt_presence_tracker.sv
// Scoreboard bench: driver tasks queue expected responses and victims, a
// monitor compares them as the tracker produces them.
module test_ppt_presence_tracker;

    localparam int BA_W = 34;
    localparam int BLKS = 64;
    localparam int PW   = 28;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lkp_valid = 1'b0;
    logic [BA_W-1:0] lkp_blk_addr = '0;
    logic            rsp_valid, rsp_present;
    logic            upd_valid = 1'b0;
    logic            upd_op = 1'b0;
    logic [BA_W-1:0] upd_blk_addr = '0;
    logic            upd_ready;
    logic            vic_valid;
    logic            vic_ready = 1'b1;
    logic [PW-1:0]   vic_page;
    logic [BLKS-1:0] vic_vec;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    bit    q_exp[$];
    int    q_cyc[$];
    string q_req[$];
    logic [PW-1:0]   v_page[$];
    logic [BLKS-1:0] v_vec[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    ppt_presence_tracker i_ppt_presence_tracker (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_blk_addr(lkp_blk_addr),
        .rsp_valid(rsp_valid), .rsp_present(rsp_present), .upd_valid(upd_valid),
        .upd_op(upd_op), .upd_blk_addr(upd_blk_addr), .upd_ready(upd_ready),
        .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_page(vic_page), .vic_vec(vic_vec)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [BA_W-1:0] mk(input int tag, input int set, input int blk);
        return {tag[19:0], set[7:0], blk[5:0]};
    endfunction

    function automatic logic [PW-1:0] pg(input int tag, input int set);
        return {tag[19:0], set[7:0]};
    endfunction

    // Driver tasks: called at a negedge, return at the next negedge.
    task automatic lookup(input logic [BA_W-1:0] a, input bit exp, input string req);
        lkp_valid = 1'b1; lkp_blk_addr = a;
        q_exp.push_back(exp); q_cyc.push_back(cyc); q_req.push_back(req);
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    task automatic update(input bit op, input logic [BA_W-1:0] a);
        while (!upd_ready) @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_blk_addr = a;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic combo(input bit op, input logic [BA_W-1:0] ua,
                         input logic [BA_W-1:0] la, input bit exp, input string req);
        while (!upd_ready) @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_blk_addr = ua;
        lkp_valid = 1'b1; lkp_blk_addr = la;
        q_exp.push_back(exp); q_cyc.push_back(cyc); q_req.push_back(req);
        @(negedge clk);
        upd_valid = 1'b0; lkp_valid = 1'b0;
    endtask

    task automatic expect_victim(input logic [PW-1:0] p, input logic [BLKS-1:0] v);
        v_page.push_back(p); v_vec.push_back(v);
    endtask

    // Monitor: sample after the negedge drivers, far from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rsp_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R3 unexpected response", 64'(rsp_valid), 64'd0);
                end else begin
                    bit e; int c; string r;
                    e = q_exp.pop_front(); c = q_cyc.pop_front(); r = q_req.pop_front();
                    check(cyc == c + 1, "R3 latency", 64'(cyc - c), 64'd1);
                    check(rsp_present == e, r, 64'(rsp_present), 64'(e));
                end
            end
            if (rst_n && vic_valid && vic_ready) begin
                if (v_page.size() == 0) begin
                    check(1'b0, "R9 unexpected victim", 64'(vic_page), 64'd0);
                end else begin
                    logic [PW-1:0] p; logic [BLKS-1:0] v;
                    p = v_page.pop_front(); v = v_vec.pop_front();
                    check(vic_page == p, "R9 victim page", 64'(vic_page), 64'(p));
                    check(vic_vec == v, "R9 victim vector", vic_vec, v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(upd_ready == 1'b1, "R1 upd_ready", 64'(upd_ready), 64'd1);
        check(vic_valid == 1'b0, "R1 vic_valid", 64'(vic_valid), 64'd0);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        lookup(mk(1, 5, 3), 1'b0, "R1 empty table");
        lookup(mk(0, 0, 0), 1'b0, "R1 empty table");

        // R2 with back-to-back lookups (R3 pipelining)
        update(1'b0, mk(1, 5, 3));
        lookup(mk(1, 5, 3), 1'b1, "R2 filled block");
        lookup(mk(1, 5, 4), 1'b0, "R2 neighbour block");
        lookup(mk(2, 5, 3), 1'b0, "R2 other tag");
        lookup(mk(1, 6, 3), 1'b0, "R2 other set");

        // R4 same-cycle fill forwarding
        combo(1'b0, mk(3, 5, 10), mk(3, 5, 10), 1'b1, "R4 forwarded fill");
        lookup(mk(3, 5, 10), 1'b1, "R4 fill retained");
        combo(1'b0, mk(3, 5, 11), mk(3, 5, 12), 1'b0, "R4 no forward to other block");

        // R5 same-cycle evict forwarding
        combo(1'b1, mk(1, 5, 3), mk(1, 5, 3), 1'b0, "R5 forwarded evict");
        lookup(mk(1, 5, 3), 1'b0, "R5 evict retained");

        // R6 evict clears only one bit
        update(1'b0, mk(4, 5, 20));
        update(1'b0, mk(4, 5, 40));
        update(1'b1, mk(4, 5, 20));
        lookup(mk(4, 5, 20), 1'b0, "R6 cleared block");
        lookup(mk(4, 5, 40), 1'b1, "R6 kept block");

        // R9/R10/R11: fill set 9 past capacity
        update(1'b0, mk(10, 9, 2));
        update(1'b0, mk(10, 9, 7));
        update(1'b0, mk(11, 9, 5));
        update(1'b0, mk(12, 9, 1));
        update(1'b0, mk(13, 9, 0));
        check(vic_valid == 1'b0, "R9 free ways used", 64'(vic_valid), 64'd0);
        lookup(mk(10, 9, 2), 1'b1, "R10 lookup does not refresh");
        update(1'b0, mk(11, 9, 5));           // R10 refresh of tracked page
        vic_ready = 1'b0;
        expect_victim(pg(10, 9), 64'h84);
        update(1'b0, mk(14, 9, 3));
        for (int i = 0; i < 3; i++) begin
            check(vic_valid == 1'b1, "R11 victim held", 64'(vic_valid), 64'd1);
            check(upd_ready == 1'b0, "R11 updates stalled", 64'(upd_ready), 64'd0);
            check(vic_page == pg(10, 9), "R11 page stable", 64'(vic_page), 64'(pg(10, 9)));
            @(negedge clk);
        end
        vic_ready = 1'b1;
        @(negedge clk);
        check(vic_valid == 1'b0, "R11 victim retired", 64'(vic_valid), 64'd0);
        check(upd_ready == 1'b1, "R11 updates resume", 64'(upd_ready), 64'd1);
        lookup(mk(10, 9, 2), 1'b0, "R9 displaced page absent");
        lookup(mk(10, 9, 7), 1'b0, "R9 displaced page absent");
        lookup(mk(14, 9, 3), 1'b1, "R9 new page present");
        lookup(mk(11, 9, 5), 1'b1, "R10 refreshed page kept");

        expect_victim(pg(12, 9), 64'h2);      // R10: C is oldest, not B
        update(1'b0, mk(15, 9, 6));
        repeat (2) @(negedge clk);
        lookup(mk(12, 9, 1), 1'b0, "R10 oldest displaced");
        lookup(mk(11, 9, 5), 1'b1, "R10 refreshed survives");

        // R7 emptied entry is reused without a victim
        update(1'b1, mk(13, 9, 0));
        update(1'b0, mk(16, 9, 4));
        check(vic_valid == 1'b0, "R7 no victim on reuse", 64'(vic_valid), 64'd0);
        @(negedge clk);
        check(vic_valid == 1'b0, "R7 no victim on reuse", 64'(vic_valid), 64'd0);
        lookup(mk(13, 9, 0), 1'b0, "R7 emptied page absent");
        lookup(mk(16, 9, 4), 1'b1, "R7 reused way holds page");
        lookup(mk(14, 9, 3), 1'b1, "R7 others kept");
        lookup(mk(15, 9, 6), 1'b1, "R7 others kept");

        // R8 harmless evicts
        update(1'b1, mk(85, 9, 0));
        update(1'b1, mk(11, 9, 9));
        check(vic_valid == 1'b0, "R8 no victim", 64'(vic_valid), 64'd0);
        lookup(mk(11, 9, 5), 1'b1, "R8 tracked bit kept");
        lookup(mk(11, 9, 9), 1'b0, "R8 clear bit stays clear");
        lookup(mk(85, 9, 0), 1'b0, "R8 untracked stays absent");
        expect_victim(pg(11, 9), 64'h20);     // R8: order unchanged, B is oldest
        update(1'b0, mk(17, 9, 8));
        repeat (2) @(negedge clk);
        lookup(mk(17, 9, 8), 1'b1, "R9 new page present");
        lookup(mk(11, 9, 5), 1'b0, "R8 expected victim gone");

        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R3 all responses seen", 64'(q_exp.size()), 64'd0);
        check(v_page.size() == 0, "R9 all victims seen", 64'(v_page.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule